// File: doc/BRIEF.md
# CPU Reset and Init Sideband Controller

This block drives the sideband lines that restart and steer the processor: a hard reset, a soft init pulse, an address-bit-20 mask and an ignore-numeric-error line. It also raises an internal IRQ13 from the coprocessor error input. It runs on the PCI clock. The power-good input is its only reset: while power-good is low, hard reset is held active and every internal register returns to its default.

Four events start a soft init: a keyboard-controller reset request, a decoded shutdown special cycle, a register write that starts a CPU reset with the system-reset select clear, and a write that sets the fast-init bit of the port-92 register. All of them feed one counter, so init is a pulse of fixed length. A request that arrives while a pulse is already running is absorbed into that pulse. The same CPU-reset write with the system-reset select set starts a hard reset instead. While a hard reset is active, the block holds its own registers cleared and reports this on a clear output, so that neighbouring register banks can reset themselves. A strap input sets the active level of hard reset and init.

Top module: `cpusb_ctrl`

## Requirements
- R1: While power-good is low, hard reset is active. After power-good rises, hard reset stays active for exactly HRST_CYCLES clock cycles, counted from the cycle in which power-good rose, and is released on a clock edge.
- R2: A reset-control write with data bit 1 (reset CPU) going from a stored 0 to 1 while data bit 0 (system-reset select) is 1 starts a hard reset. The hard reset is active for HRST_CYCLES cycles from the next cycle and also ends any running init. The clear output equals the active hard-reset state.
- R3: Init starts in the cycle after any one of these: a 0-to-1 change of the keyboard reset request; a one-cycle shutdown strobe; a reset-control write taking reset CPU from 0 to 1 with system-reset select 0; a port-92 write taking data bit 0 (fast init) from a stored 0 to 1.
- R4: Once started, init is active for exactly INIT_CYCLES cycles and then releases.
- R5: An init request that arrives while init is active neither extends nor restarts the pulse.
- R6: With the strap at 0, hard reset and init are active-high. With the strap at 1, both are active-low.
- R7: The A20 mask output is 1 exactly when the gate input is 0 and the stored port-92 data bit 1 (fast A20) is 0. A port-92 write affects the mask from the next cycle.
- R8: IRQ13 equals the coprocessor error input as sampled on the previous clock edge.
- R9: Ignore-numeric-error asserts in the cycle after a coprocessor-error register write made while error reporting is enabled and the error input is 1.
- R10: A coprocessor-error register write made while the error input is 0, or while error reporting is disabled, leaves ignore-numeric-error at 0.
- R11: Once asserted, ignore-numeric-error stays at 1 until the error input is sampled at 0, and is 0 in the following cycle.
- R12: During a hard reset, register writes, shutdown strobes and keyboard requests are ignored, init stays inactive, and the reset-control and port-92 registers and ignore-numeric-error are cleared.
- R13: A write that leaves reset CPU or fast init at an already-stored 1 starts no init.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PCI clock |
| pwrgood_i | input | 1 | Power good, low clears the block asynchronously |
| kbd_rst_req_i | input | 1 | Keyboard controller reset request, active high |
| shutdown_i | input | 1 | One-cycle strobe for a decoded shutdown special cycle |
| rstctl_we_i | input | 1 | Reset-control register write strobe |
| rstctl_wdata_i | input | 2 | Bit 1 reset CPU, bit 0 system-reset select |
| port92_we_i | input | 1 | Port-92 register write strobe |
| port92_wdata_i | input | 2 | Bit 1 fast A20, bit 0 fast init |
| fpuerr_we_i | input | 1 | Coprocessor-error register write strobe |
| a20_gate_i | input | 1 | External A20 gate |
| fpu_err_i | input | 1 | Coprocessor error, active high |
| err_rpt_en_i | input | 1 | Coprocessor error reporting enable |
| cpu_low_sel_i | input | 1 | Strap: 1 makes hard reset and init active-low |
| cpu_hrst_o | output | 1 | Processor hard reset, level set by the strap |
| cpu_init_o | output | 1 | Processor soft init, level set by the strap |
| a20_mask_o | output | 1 | 1 forces address bit 20 low |
| ignne_o | output | 1 | Ignore numeric error, active high |
| irq13_o | output | 1 | Internal coprocessor interrupt request |
| regs_clr_o | output | 1 | Clear request to the register banks during hard reset |

## Verification
Directed sequences measure the pulse lengths from power-good and from a register hard reset, and fire each init source alone. This shows which of the four sources is broken and whether the counter is off by one. A keyboard request injected in the middle of a shutdown-started pulse tells absorption apart from a restart. Writes that repeat an already-set bit tell edge detection apart from level detection. Requests and writes issued during a hard reset show that the clear has priority. The error handshake is driven in four states (error low, enable low, both high, error dropping), which tells the gating condition apart from the hold condition. Random traffic under both strap levels is then compared each cycle with a bench model, which catches interactions such as a hard reset cutting off a running init.

// File: rtl/cpusb_pkg.sv
package cpusb_pkg;

  // bit positions inside the 2-bit write data buses
  localparam int RC_SYSSEL_BIT = 0;
  localparam int RC_CPURST_BIT = 1;
  localparam int P92_INIT_BIT  = 0;
  localparam int P92_A20_BIT   = 1;

  typedef struct packed {
    logic kbd;
    logic shutdown;
    logic rc_soft;
    logic p92;
  } init_src_t;

  function automatic logic rise_f(logic now_v, logic prev_v);
    return now_v & ~prev_v;
  endfunction

  function automatic logic any_src_f(init_src_t s);
    return |s;
  endfunction

  function automatic logic a20_mask_f(logic gate, logic fast);
    return ~(gate | fast);
  endfunction

  function automatic logic polar_f(logic act, logic low_sel);
    return act ^ low_sel;
  endfunction

endpackage

// File: rtl/cpusb_hrst_timer.sv
module cpusb_hrst_timer #(
  parameter int CYCLES = 66000
) (
  input  logic clk_i,
  input  logic pwrgood_i,
  input  logic load_i,
  output logic active_o
);
  localparam int W = $clog2(CYCLES + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge pwrgood_i) begin
    if (!pwrgood_i)          cnt_q <= W'(CYCLES);
    else if (load_i)         cnt_q <= W'(CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/cpusb_init_gen.sv
module cpusb_init_gen
  import cpusb_pkg::*;
#(
  parameter int CYCLES = 64
) (
  input  logic      clk_i,
  input  logic      pwrgood_i,
  input  logic      hold_i,
  input  init_src_t src_i,
  output logic      trig_o,
  output logic      active_o
);
  localparam int W = $clog2(CYCLES + 1);

  logic [W-1:0] cnt_q;

  assign trig_o   = any_src_f(src_i) & ~hold_i;
  assign active_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge pwrgood_i) begin
    if (!pwrgood_i)      cnt_q <= '0;
    else if (hold_i)     cnt_q <= '0;
    else if (active_o)   cnt_q <= cnt_q - 1'b1;
    else if (trig_o)     cnt_q <= W'(CYCLES);
  end
endmodule

// File: rtl/cpusb_fpu_err.sv
module cpusb_fpu_err (
  input  logic clk_i,
  input  logic pwrgood_i,
  input  logic clr_i,
  input  logic err_i,
  input  logic en_i,
  input  logic we_i,
  output logic set_o,
  output logic ignne_o,
  output logic irq13_o
);
  logic ign_q;
  logic irq_q;

  assign set_o = en_i & we_i & err_i;

  always_ff @(posedge clk_i or negedge pwrgood_i) begin
    if (!pwrgood_i) begin
      ign_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= err_i;
      if (clr_i) ign_q <= 1'b0;
      else       ign_q <= err_i & (ign_q | set_o);
    end
  end

  assign ignne_o = ign_q;
  assign irq13_o = irq_q;
endmodule

// File: rtl/cpusb_ctrl.sv
module cpusb_ctrl
  import cpusb_pkg::*;
#(
  parameter int HRST_CYCLES = 66000,
  parameter int INIT_CYCLES = 64
) (
  input  logic       clk_i,
  input  logic       pwrgood_i,
  input  logic       kbd_rst_req_i,
  input  logic       shutdown_i,
  input  logic       rstctl_we_i,
  input  logic [1:0] rstctl_wdata_i,
  input  logic       port92_we_i,
  input  logic [1:0] port92_wdata_i,
  input  logic       fpuerr_we_i,
  input  logic       a20_gate_i,
  input  logic       fpu_err_i,
  input  logic       err_rpt_en_i,
  input  logic       cpu_low_sel_i,
  output logic       cpu_hrst_o,
  output logic       cpu_init_o,
  output logic       a20_mask_o,
  output logic       ignne_o,
  output logic       irq13_o,
  output logic       regs_clr_o
);
  localparam int NUM_POL = 2;

  // named internal events
  logic      hrst_act;
  logic      init_act;
  logic      init_trig;
  logic      kbd_rise;
  logic      rc_rise;
  logic      hard_req;
  logic      soft_req;
  logic      p92_req;
  logic      ign_set;
  init_src_t srcs;

  logic       kbd_q;
  logic       cpurst_q;
  logic [1:0] p92_q;

  assign kbd_rise = rise_f(kbd_rst_req_i, kbd_q);
  assign rc_rise  = rstctl_we_i & ~hrst_act
                  & rise_f(rstctl_wdata_i[RC_CPURST_BIT], cpurst_q);
  assign hard_req = rc_rise &  rstctl_wdata_i[RC_SYSSEL_BIT];
  assign soft_req = rc_rise & ~rstctl_wdata_i[RC_SYSSEL_BIT];
  assign p92_req  = port92_we_i & ~hrst_act
                  & rise_f(port92_wdata_i[P92_INIT_BIT], p92_q[P92_INIT_BIT]);

  assign srcs.kbd      = kbd_rise;
  assign srcs.shutdown = shutdown_i;
  assign srcs.rc_soft  = soft_req;
  assign srcs.p92      = p92_req;

  always_ff @(posedge clk_i or negedge pwrgood_i) begin
    if (!pwrgood_i) begin
      kbd_q    <= 1'b0;
      cpurst_q <= 1'b0;
      p92_q    <= '0;
    end else begin
      kbd_q <= kbd_rst_req_i;
      if (hrst_act) begin
        cpurst_q <= 1'b0;
        p92_q    <= '0;
      end else begin
        if (rstctl_we_i) cpurst_q <= rstctl_wdata_i[RC_CPURST_BIT];
        if (port92_we_i) p92_q    <= port92_wdata_i;
      end
    end
  end

  cpusb_hrst_timer #(.CYCLES(HRST_CYCLES)) u_hrst (
    .clk_i     (clk_i),
    .pwrgood_i (pwrgood_i),
    .load_i    (hard_req),
    .active_o  (hrst_act)
  );

  cpusb_init_gen #(.CYCLES(INIT_CYCLES)) u_init (
    .clk_i     (clk_i),
    .pwrgood_i (pwrgood_i),
    .hold_i    (hrst_act | hard_req),
    .src_i     (srcs),
    .trig_o    (init_trig),
    .active_o  (init_act)
  );

  cpusb_fpu_err u_ferr (
    .clk_i     (clk_i),
    .pwrgood_i (pwrgood_i),
    .clr_i     (hrst_act),
    .err_i     (fpu_err_i),
    .en_i      (err_rpt_en_i),
    .we_i      (fpuerr_we_i),
    .set_o     (ign_set),
    .ignne_o   (ignne_o),
    .irq13_o   (irq13_o)
  );

  // strap-selected output level, one lane per processor control line
  logic [NUM_POL-1:0] act_vec;
  logic [NUM_POL-1:0] pin_vec;
  assign act_vec = {init_act, hrst_act};

  for (genvar g = 0; g < NUM_POL; g++) begin : g_pol
    assign pin_vec[g] = polar_f(act_vec[g], cpu_low_sel_i);
  end

  assign cpu_hrst_o = pin_vec[0];
  assign cpu_init_o = pin_vec[1];
  assign a20_mask_o = a20_mask_f(a20_gate_i, p92_q[P92_A20_BIT]);
  assign regs_clr_o = hrst_act;
endmodule

// File: rtl/cpusb_ctrl_chk.sv
module cpusb_ctrl_chk #(
  parameter int HRST_CYCLES = 66000,
  parameter int INIT_CYCLES = 64
) (
  input logic clk_i,
  input logic pwrgood_i,
  input logic hrst_act,
  input logic init_act,
  input logic init_trig,
  input logic ign_set,
  input logic fpu_err_i,
  input logic a20_gate_i,
  input logic a20_mask_o,
  input logic ignne_o,
  input logic irq13_o
);
  localparam int HW = $clog2(HRST_CYCLES + 2);
  localparam int IW = $clog2(INIT_CYCLES + 2);

  logic [HW-1:0] hlen_q;
  logic [IW-1:0] ilen_q;
  logic          up_q;

  always_ff @(posedge clk_i or negedge pwrgood_i) begin
    if (!pwrgood_i) begin
      hlen_q <= '0;
      ilen_q <= '0;
      up_q   <= 1'b0;
    end else begin
      up_q   <= 1'b1;
      hlen_q <= hrst_act ? hlen_q + 1'b1 : '0;
      ilen_q <= init_act ? ilen_q + 1'b1 : '0;
    end
  end

  AST_HRST_FULL_LEN: assert property (@(posedge clk_i) disable iff (!pwrgood_i)
    $fell(hrst_act) |-> hlen_q == HW'(HRST_CYCLES)); // R1
  AST_INIT_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!pwrgood_i)
    $rose(init_act) |-> $past(init_trig)); // R3
  AST_INIT_FIXED_LEN: assert property (@(posedge clk_i) disable iff (!pwrgood_i)
    ($fell(init_act) && !hrst_act) |-> ilen_q == IW'(INIT_CYCLES)); // R4
  AST_INIT_NO_STRETCH: assert property (@(posedge clk_i) disable iff (!pwrgood_i)
    ilen_q <= IW'(INIT_CYCLES)); // R5
  AST_INIT_HELD_OFF: assert property (@(posedge clk_i) disable iff (!pwrgood_i)
    hrst_act |-> !init_act); // R12
  AST_A20_GATE_OPEN: assert property (@(posedge clk_i) disable iff (!pwrgood_i)
    a20_gate_i |-> !a20_mask_o); // R7
  AST_IRQ13_TRACK: assert property (@(posedge clk_i) disable iff (!pwrgood_i)
    up_q |-> irq13_o == $past(fpu_err_i)); // R8
  AST_IGNNE_SET_COND: assert property (@(posedge clk_i) disable iff (!pwrgood_i)
    $rose(ignne_o) |-> $past(ign_set)); // R9
  AST_IGNNE_DROP: assert property (@(posedge clk_i) disable iff (!pwrgood_i)
    !fpu_err_i |=> !ignne_o); // R11
endmodule

bind cpusb_ctrl cpusb_ctrl_chk #(
  .HRST_CYCLES (HRST_CYCLES),
  .INIT_CYCLES (INIT_CYCLES)
) u_chk (
  .clk_i      (clk_i),
  .pwrgood_i  (pwrgood_i),
  .hrst_act   (hrst_act),
  .init_act   (init_act),
  .init_trig  (init_trig),
  .ign_set    (ign_set),
  .fpu_err_i  (fpu_err_i),
  .a20_gate_i (a20_gate_i),
  .a20_mask_o (a20_mask_o),
  .ignne_o    (ignne_o),
  .irq13_o    (irq13_o)
);

// File: tb/cpusb_ctrl_bench.sv
module cpusb_ctrl_bench;
  localparam int HC = 40;
  localparam int IC = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       pwrgood = 1'b0, kbd = 1'b0, shut = 1'b0;
  logic       rc_we = 1'b0, p92_we = 1'b0, fe_we = 1'b0;
  logic [1:0] rc_wd = 2'b00, p92_wd = 2'b00;
  logic       gate = 1'b0, ferr = 1'b0, en = 1'b0, strap = 1'b0;
  logic       hrst_o, init_o, a20m_o, ign_o, irq_o, clr_o;

  cpusb_ctrl #(.HRST_CYCLES(HC), .INIT_CYCLES(IC)) u_cpusb_ctrl (
    .clk_i(clk), .pwrgood_i(pwrgood), .kbd_rst_req_i(kbd), .shutdown_i(shut),
    .rstctl_we_i(rc_we), .rstctl_wdata_i(rc_wd), .port92_we_i(p92_we),
    .port92_wdata_i(p92_wd), .fpuerr_we_i(fe_we), .a20_gate_i(gate),
    .fpu_err_i(ferr), .err_rpt_en_i(en), .cpu_low_sel_i(strap),
    .cpu_hrst_o(hrst_o), .cpu_init_o(init_o), .a20_mask_o(a20m_o),
    .ignne_o(ign_o), .irq13_o(irq_o), .regs_clr_o(clr_o));

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_pin(bit active, bit low_sel);
    if (low_sel) return active ? 0 : 1;
    return active ? 1 : 0;
  endfunction

  function automatic int exp_a20(bit g, bit fast);
    if (g || fast) return 0;
    return 1;
  endfunction

  // cycle model built from the requirements
  int m_h, m_i;
  bit m_rc, m_p0, m_p1, m_kb, m_ign, m_irq, m_ok = 0;

  always @(posedge clk) begin
    if (!pwrgood) begin
      m_h = HC; m_i = 0; m_rc = 0; m_p0 = 0; m_p1 = 0;
      m_kb = 0; m_ign = 0; m_irq = 0; m_ok = 1;
    end else begin
      bit hact, rc_trig, hard, req;
      hact    = (m_h > 0);
      rc_trig = !hact && rc_we && rc_wd[1] && !m_rc;
      hard    = rc_trig && rc_wd[0];
      req     = !hact && ((kbd && !m_kb) || shut || (rc_trig && !rc_wd[0])
                || (p92_we && p92_wd[0] && !m_p0));
      m_kb  = kbd;
      m_irq = ferr;
      m_ign = hact ? 0 : (ferr && (m_ign || (en && fe_we && ferr)));
      if (hact || hard) m_i = 0;
      else if (m_i > 0) m_i = m_i - 1;
      else if (req)     m_i = IC;
      if (hard)      m_h = HC;
      else if (hact) m_h = m_h - 1;
      if (hact) begin m_rc = 0; m_p0 = 0; m_p1 = 0; end
      else begin
        if (rc_we)  m_rc = rc_wd[1];
        if (p92_we) begin m_p0 = p92_wd[0]; m_p1 = p92_wd[1]; end
      end
    end
    #5;
    if (m_ok) begin
      check("R1 model hard reset", hrst_o, exp_pin(m_h > 0, strap));
      check("R4 model init", init_o, exp_pin(m_i > 0, strap));
      check("R7 model a20 mask", a20m_o, exp_a20(gate, m_p1));
      check("R9 model ignne", ign_o, m_ign);
      check("R8 model irq13", irq_o, m_irq);
      check("R2 model clear", clr_o, (m_h > 0) ? 1 : 0);
    end
  end

  task automatic tick(); @(negedge clk); endtask
  function automatic bit init_on(); return init_o != strap; endfunction
  function automatic bit hrst_on(); return hrst_o != strap; endfunction

  task automatic len_init(output int n);
    n = 0;
    while (init_on() && n < 1000) begin n++; tick(); end
  endtask
  task automatic len_hrst(output int n);
    n = 0;
    while (hrst_on() && n < 1000) begin n++; tick(); end
  endtask

  task automatic rc_write(logic [1:0] d);
    rc_we = 1; rc_wd = d; tick(); rc_we = 0;
  endtask
  task automatic p92_write(logic [1:0] d);
    p92_we = 1; p92_wd = d; tick(); p92_we = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(64'd20 * 64'd200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_c0de));
    repeat (3) tick();
    check("R1 reset hard reset", hrst_on(), 1);
    check("R2 reset clear", clr_o, 1);
    check("R6 reset init off", init_on(), 0);
    pwrgood = 1;
    len_hrst(n); check("R1 power-good length", n, HC);

    rc_write(2'b10);
    check("R3 rc soft init", init_on(), 1);
    len_init(n); check("R4 init length", n, IC);
    rc_write(2'b10);
    check("R13 rc bit already set", init_on(), 0);
    rc_write(2'b00);

    shut = 1; tick(); shut = 0;
    check("R3 shutdown init", init_on(), 1);
    n = 0;
    repeat (10) begin if (init_on()) n++; tick(); end
    kbd = 1;
    begin int m; len_init(m); n += m; end
    check("R5 absorbed request", n, IC);
    kbd = 0; tick(); kbd = 1; tick();
    check("R3 keyboard init", init_on(), 1);
    len_init(n); check("R4 keyboard length", n, IC);
    kbd = 0;

    gate = 0;
    p92_write(2'b01);
    check("R3 port92 init", init_on(), 1);
    len_init(n);
    p92_write(2'b11);
    check("R13 port92 bit already set", init_on(), 0);
    check("R7 fast a20 opens mask", a20m_o, 0);
    p92_write(2'b00);
    check("R7 mask closed", a20m_o, 1);
    gate = 1; tick();
    check("R7 gate opens mask", a20m_o, 0);
    gate = 0;

    en = 1; ferr = 0; fe_we = 1; tick(); fe_we = 0;
    check("R10 write without error", ign_o, 0);
    ferr = 1; tick();
    check("R8 irq13 follows error", irq_o, 1);
    en = 0; fe_we = 1; tick(); fe_we = 0;
    check("R10 write with reporting off", ign_o, 0);
    en = 1; fe_we = 1; tick(); fe_we = 0;
    check("R9 ignne set", ign_o, 1);
    repeat (3) tick();
    check("R11 ignne held", ign_o, 1);
    ferr = 0; tick();
    check("R11 ignne dropped", ign_o, 0);
    check("R8 irq13 dropped", irq_o, 0);

    kbd = 0;
    shut = 1; tick(); shut = 0;
    repeat (5) tick();
    rc_write(2'b11);
    check("R2 register hard reset", hrst_on(), 1);
    check("R2 clear output", clr_o, 1);
    check("R2 init cut off", init_on(), 0);
    p92_write(2'b01);
    shut = 1; tick(); shut = 0;
    len_hrst(n); check("R2 hard reset length", n, HC - 2);
    check("R12 requests ignored", init_on(), 0);
    tick();
    check("R12 still no init", init_on(), 0);
    p92_write(2'b01);
    check("R12 port92 was cleared", init_on(), 1);
    len_init(n);

    pwrgood = 0; strap = 1; ferr = 0;
    repeat (3) tick();
    check("R6 low hard reset level", hrst_o, 0);
    check("R6 low init idle level", init_o, 1);
    pwrgood = 1;
    len_hrst(n); check("R1 length under low strap", n, HC);
    rc_write(2'b10);
    check("R6 low init level", init_o, 0);
    len_init(n); check("R4 length under low strap", n, IC);

    for (int ph = 0; ph < 2; ph++) begin
      for (int c = 0; c < 3000; c++) begin
        rc_we  = ($urandom_range(0, 31) == 0);
        rc_wd  = 2'($urandom);
        p92_we = ($urandom_range(0, 15) == 0);
        p92_wd = 2'($urandom);
        shut   = ($urandom_range(0, 63) == 0);
        fe_we  = ($urandom_range(0, 3) == 0);
        en     = ($urandom_range(0, 7) != 0);
        if ($urandom_range(0, 31) == 0) kbd  = ~kbd;
        if ($urandom_range(0, 7)  == 0) ferr = ~ferr;
        if ($urandom_range(0, 7)  == 0) gate = ~gate;
        tick();
      end
      rc_we = 0; p92_we = 0; shut = 0; fe_we = 0;
      pwrgood = 0; strap = ~strap;
      repeat (3) tick();
      pwrgood = 1;
    end

    repeat (2) tick();
    done = 1;
    summary();
    $finish;
  end
endmodule